// File: doc/BRIEF.md
# Length-Bounded Packet Transmit Framer

This block turns bytes waiting in a transmit FIFO into a framed serial packet. Each packet starts with a run of alternating-bit training bytes (0xAA), carries a 16-bit synchronisation word next, and ends with a payload taken from the FIFO. The number of payload bytes per packet is programmable. When that count is reached the framer drops back to idle and raises a sticky packet-sent flag. Any bytes still in the FIFO stay there until the controller issues another start command.

A controller loads the FIFO, sets the training length, the sync word and the payload length, and pulses `start_i`. Bits leave MSB first, one for each `bit_tick_i` strobe, and each appears on `tx_bit_o` with a one-cycle `tx_valid_o` pulse. If the FIFO runs dry before the programmed count is reached, the packet is cut short and an underflow flag is raised in place of packet-sent.

Top module: `pkt_tx_framer`

## Requirements
- R1: A packet is `pre_len_i` bytes of 0xAA, then the 16-bit `sync_word_i`, then the payload bytes in FIFO order. Every field is sent MSB first.
- R2: Exactly one bit is shifted out for each `bit_tick_i` cycle seen while busy. That bit appears on `tx_bit_o` with `tx_valid_o` high in the following cycle. Without a tick, `tx_valid_o` stays low and the framer holds its place.
- R3: One start command sends exactly `pkt_len_i` payload bytes and then returns to idle (`busy_o` low). Bytes left in the FIFO are not read until the next start command.
- R4: `sent_irq_o` rises when the final bit of a complete packet leaves, and it stays high until `irq_clr_i[0]` is written as 1. A set and a clear in the same cycle leave the flag set.
- R5: A start pulse while busy is ignored. The training length, sync word and payload length are captured at the accepted start, so later changes to those inputs do not affect the packet in flight.
- R6: If the FIFO is empty when the next payload byte is needed, the packet ends at once and the framer goes idle. It then sets `underflow_o` (sticky, cleared by `irq_clr_i[1]`) and does not set `sent_irq_o`.
- R7: A training length of 0 starts the packet directly with the sync word. A payload length of 0 sends training and sync only, reads nothing from the FIFO, and sets `sent_irq_o`.
- R8: After reset the framer is idle, and `tx_valid_o`, `fifo_rd_o`, `sent_irq_o` and `underflow_o` are all 0.
- R9: `fifo_rd_o` pops the FIFO head once per payload byte. It pulses only when the FIFO is not empty, in the same cycle the previous field's last bit is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-transmit command pulse |
| pkt_len_i | input | LEN_W | Payload bytes per packet |
| pre_len_i | input | PRE_W | Number of 0xAA training bytes |
| sync_word_i | input | SYNC_W | Synchronisation word |
| irq_clr_i | input | 2 | Write-one-to-clear: bit0 sent flag, bit1 underflow flag |
| fifo_empty_i | input | 1 | FIFO has no data |
| fifo_data_i | input | 8 | FIFO head byte (show-ahead) |
| fifo_rd_o | output | 1 | Pop FIFO head |
| bit_tick_i | input | 1 | Bit-rate strobe |
| tx_bit_o | output | 1 | Serial bit |
| tx_valid_o | output | 1 | Serial bit strobe |
| busy_o | output | 1 | Packet in progress |
| sent_irq_o | output | 1 | Sticky packet-sent flag |
| underflow_o | output | 1 | Sticky FIFO-underflow flag |

## Verification
The bench queues nine bytes and sends them with a length of three across three starts. A design that kept draining the FIFO after the first packet, or that lost FIFO order, fails on the leftover count or the bit stream. Separate cases cover:
- a zero training length and a zero payload length, where an off-by-one counter would add or drop a byte;
- a FIFO that runs dry mid-packet, where a wrong design would read an empty FIFO or raise packet-sent;
- a second start and new configuration applied mid-packet, which a framer that failed to latch its settings would obey;
- pauses in the bit strobe, during which a free-running shifter would emit bits;
- a clear request on the other flag's bit, which must leave the sent flag untouched.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_SYNC, ST_DATA} tx_state_e;

  localparam logic [7:0] TRAIN_BYTE = 8'hAA;

  // Total serial bits in a complete packet.
  function automatic logic [15:0] frame_bits(input int unsigned pre,
                                             input int unsigned len,
                                             input int unsigned sync_w);
    return 16'(pre * 8 + sync_w + len * 8);
  endfunction
endpackage

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int SR_W  = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SR_W-1:0]  load_val_i,
  input  logic [CNT_W-1:0] load_bits_i,
  input  logic             shift_i,
  output logic             last_bit_o,
  output logic             bit_o,
  output logic             valid_o
);
  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] bits_left_q;

  assign last_bit_o = shift_i && (bits_left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q        <= '0;
      bits_left_q <= '0;
      bit_o       <= 1'b0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= shift_i;
      if (shift_i) bit_o <= sr_q[SR_W-1];
      if (load_i) begin
        sr_q        <= load_val_i;
        bits_left_q <= load_bits_i;
      end else if (shift_i) begin
        sr_q        <= {sr_q[SR_W-2:0], 1'b0};
        bits_left_q <= bits_left_q - 1'b1;
      end
    end
  end

  // R2: a shift is never requested with no bits loaded
  assert_shift_has_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (bits_left_q != '0));
endmodule

// File: rtl/tx_seq.sv
module tx_seq
  import pkt_tx_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int LEN_W  = 8,
  parameter int SYNC_W = 16,
  parameter int SR_W   = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PRE_W-1:0]  pre_len_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [SYNC_W-1:0] sync_i,
  input  logic              fifo_empty_i,
  input  logic [7:0]        fifo_data_i,
  input  logic              shift_i,
  input  logic              last_bit_i,
  output logic              load_o,
  output logic [SR_W-1:0]   load_val_o,
  output logic [CNT_W-1:0]  load_bits_o,
  output logic              fifo_rd_o,
  output logic              busy_o,
  output logic              done_ev_o,
  output logic              unf_ev_o
);
  tx_state_e         state_q, state_d;
  logic [PRE_W-1:0]  pre_left_q, pre_left_d;
  logic [LEN_W-1:0]  data_left_q, data_left_d;
  logic [SYNC_W-1:0] sync_q, sync_d;
  logic              start_acc;

  function automatic logic [SR_W-1:0] place_byte(input logic [7:0] b);
    logic [SR_W-1:0] v;
    v = '0;
    v[SR_W-1 -: 8] = b;
    return v;
  endfunction

  function automatic logic [SR_W-1:0] place_sync(input logic [SYNC_W-1:0] s);
    logic [SR_W-1:0] v;
    v = '0;
    v[SR_W-1 -: SYNC_W] = s;
    return v;
  endfunction

  assign busy_o    = (state_q != ST_IDLE);
  assign start_acc = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    pre_left_d  = pre_left_q;
    data_left_d = data_left_q;
    sync_d      = sync_q;
    load_o      = 1'b0;
    load_val_o  = '0;
    load_bits_o = '0;
    fifo_rd_o   = 1'b0;
    done_ev_o   = 1'b0;
    unf_ev_o    = 1'b0;
    if (start_acc) begin
      sync_d      = sync_i;
      data_left_d = pkt_len_i;
      load_o      = 1'b1;
      if (pre_len_i != '0) begin
        load_val_o  = place_byte(TRAIN_BYTE);
        load_bits_o = CNT_W'(8);
        pre_left_d  = pre_len_i - 1'b1;
        state_d     = ST_PRE;
      end else begin
        load_val_o  = place_sync(sync_i);
        load_bits_o = CNT_W'(SYNC_W);
        state_d     = ST_SYNC;
      end
    end else if (last_bit_i) begin
      unique case (state_q)
        ST_PRE: begin
          load_o = 1'b1;
          if (pre_left_q != '0) begin
            load_val_o  = place_byte(TRAIN_BYTE);
            load_bits_o = CNT_W'(8);
            pre_left_d  = pre_left_q - 1'b1;
          end else begin
            load_val_o  = place_sync(sync_q);
            load_bits_o = CNT_W'(SYNC_W);
            state_d     = ST_SYNC;
          end
        end
        ST_SYNC, ST_DATA: begin
          if (data_left_q == '0) begin
            state_d   = ST_IDLE;
            done_ev_o = 1'b1;
          end else if (fifo_empty_i) begin
            state_d  = ST_IDLE;
            unf_ev_o = 1'b1;
          end else begin
            fifo_rd_o   = 1'b1;
            load_o      = 1'b1;
            load_val_o  = place_byte(fifo_data_i);
            load_bits_o = CNT_W'(8);
            data_left_d = data_left_q - 1'b1;
            state_d     = ST_DATA;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pre_left_q  <= '0;
      data_left_q <= '0;
      sync_q      <= '0;
    end else begin
      state_q     <= state_d;
      pre_left_q  <= pre_left_d;
      data_left_q <= data_left_d;
      sync_q      <= sync_d;
    end
  end

  // Observation registers for the checks below
  logic [PRE_W-1:0] chk_pre_q;
  logic [LEN_W-1:0] chk_len_q;
  logic [LEN_W-1:0] chk_pops_q;
  logic [15:0]      chk_bits_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_pre_q  <= '0;
      chk_len_q  <= '0;
      chk_pops_q <= '0;
      chk_bits_q <= '0;
    end else if (start_acc) begin
      chk_pre_q  <= pre_len_i;
      chk_len_q  <= pkt_len_i;
      chk_pops_q <= '0;
      chk_bits_q <= '0;
    end else begin
      if (fifo_rd_o) chk_pops_q <= chk_pops_q + 1'b1;
      if (shift_i)   chk_bits_q <= chk_bits_q + 1'b1;
    end
  end

  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> !fifo_empty_i);
  assert_end_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev_o || unf_ev_o) |=> !busy_o);
  assert_pop_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev_o |-> (chk_pops_q == chk_len_q));
  assert_frame_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev_o |-> (chk_bits_q + 16'd1 ==
                   frame_bits(32'(chk_pre_q), 32'(chk_len_q), SYNC_W)));
  assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !last_bit_i) |=> ($stable(data_left_q) && $stable(sync_q)));
  assert_single_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ev_o, unf_ev_o}));
endmodule

// File: rtl/irq_flags.sv
module irq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sent_set_i,
  input  logic       unf_set_i,
  input  logic [1:0] clr_i,
  output logic       sent_o,
  output logic       unf_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_o <= 1'b0;
      unf_o  <= 1'b0;
    end else begin
      sent_o <= (sent_o && !clr_i[0]) || sent_set_i;
      unf_o  <= (unf_o  && !clr_i[1]) || unf_set_i;
    end
  end

  assert_sent_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_o && !clr_i[0]) |=> sent_o);
  assert_sent_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sent_set_i |=> sent_o);
  assert_unf_no_sent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_set_i && !sent_o) |=> (!sent_o && unf_o));
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer #(
  parameter int PRE_W  = 4,
  parameter int LEN_W  = 8,
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [PRE_W-1:0]  pre_len_i,
  input  logic [SYNC_W-1:0] sync_word_i,
  input  logic [1:0]        irq_clr_i,
  input  logic              fifo_empty_i,
  input  logic [7:0]        fifo_data_i,
  output logic              fifo_rd_o,
  input  logic              bit_tick_i,
  output logic              tx_bit_o,
  output logic              tx_valid_o,
  output logic              busy_o,
  output logic              sent_irq_o,
  output logic              underflow_o
);
  localparam int SR_W  = (SYNC_W > 8) ? SYNC_W : 8;
  localparam int CNT_W = $clog2(SR_W + 1);

  logic             shift_ev;
  logic             last_bit_ev;
  logic             load_ev;
  logic [SR_W-1:0]  load_val;
  logic [CNT_W-1:0] load_bits;
  logic             done_ev;
  logic             unf_ev;

  assign shift_ev = bit_tick_i && busy_o;

  tx_seq #(
    .PRE_W(PRE_W), .LEN_W(LEN_W), .SYNC_W(SYNC_W), .SR_W(SR_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pre_len_i(pre_len_i),
    .pkt_len_i(pkt_len_i), .sync_i(sync_word_i), .fifo_empty_i(fifo_empty_i),
    .fifo_data_i(fifo_data_i), .shift_i(shift_ev), .last_bit_i(last_bit_ev),
    .load_o(load_ev), .load_val_o(load_val), .load_bits_o(load_bits),
    .fifo_rd_o(fifo_rd_o), .busy_o(busy_o), .done_ev_o(done_ev), .unf_ev_o(unf_ev)
  );

  tx_shifter #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load_ev), .load_val_i(load_val),
    .load_bits_i(load_bits), .shift_i(shift_ev), .last_bit_o(last_bit_ev),
    .bit_o(tx_bit_o), .valid_o(tx_valid_o)
  );

  irq_flags u_irq (
    .clk(clk), .rst_n(rst_n), .sent_set_i(done_ev), .unf_set_i(unf_ev),
    .clr_i(irq_clr_i), .sent_o(sent_irq_o), .unf_o(underflow_o)
  );

  assert_valid_follows_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> tx_valid_o);
  assert_no_valid_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_ev |=> !tx_valid_o);
endmodule

// File: tb/sim_pkt_tx_framer.sv
module sim_pkt_tx_framer;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  pre;
    logic [7:0]  len;
    logic [15:0] sync;
    logic [7:0]  nq;
    logic [3:0]  per;
  } vec_t;

  // training bytes, payload length, sync, bytes queued, tick period
  localparam vec_t VECS [0:5] = '{
    '{4'd2, 8'd3, 16'h2DD4, 8'd3, 4'd1},
    '{4'd0, 8'd2, 16'hB38F, 8'd4, 4'd3},
    '{4'd1, 8'd0, 16'h1234, 8'd0, 4'd2},
    '{4'd3, 8'd4, 16'hF00F, 8'd2, 4'd1},
    '{4'd1, 8'd1, 16'h8001, 8'd0, 4'd1},
    '{4'd4, 8'd5, 16'hC3A5, 8'd5, 4'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bit_tick = 1'b0;
  logic [7:0] pkt_len = '0;
  logic [3:0] pre_len = '0;
  logic [15:0] sync_word = '0;
  logic [1:0] irq_clr = '0;
  logic fifo_empty, fifo_rd, tx_bit, tx_valid, busy, sent_irq, underflow;
  logic [7:0] fifo_data;

  int tests = 0, fails = 0;
  logic [7:0] mem [0:63];
  int rd_p = 0, wr_p = 0;
  logic [7:0] pat = 8'h3C;
  logic tick_on = 1'b0;
  int tick_per = 1, tick_cnt = 0;
  bit cap [0:1023];
  bit expb [0:1023];
  int ncap = 0, nexp = 0, exp_nsent = 0;
  bit exp_unf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fifo_empty = (rd_p == wr_p);
  assign fifo_data  = mem[rd_p % 64];

  always @(posedge clk) if (fifo_rd) rd_p <= rd_p + 1;

  always @(negedge clk) begin
    if (tx_valid) begin
      if (ncap < 1024) cap[ncap] = tx_bit;
      ncap = ncap + 1;
    end
    if (tick_on) begin
      bit_tick = ((tick_cnt % tick_per) == 0);
      tick_cnt = tick_cnt + 1;
    end else bit_tick = 1'b0;
  end

  pkt_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pkt_len_i(pkt_len),
    .pre_len_i(pre_len), .sync_word_i(sync_word), .irq_clr_i(irq_clr),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd),
    .bit_tick_i(bit_tick), .tx_bit_o(tx_bit), .tx_valid_o(tx_valid),
    .busy_o(busy), .sent_irq_o(sent_irq), .underflow_o(underflow)
  );

  task automatic chk(input string tag, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      mem[wr_p % 64] = pat;
      wr_p = wr_p + 1;
      pat = pat + 8'h3B;
    end
  endtask

  task automatic build_exp(input int pre, input int len, input logic [15:0] sw);
    int avail;
    logic [7:0] b;
    avail = wr_p - rd_p;
    exp_unf = (avail < len);
    exp_nsent = exp_unf ? avail : len;
    nexp = 0;
    for (int k = 0; k < pre; k++)
      for (int j = 7; j >= 0; j--) begin expb[nexp] = (j % 2 == 1); nexp++; end
    for (int j = 15; j >= 0; j--) begin expb[nexp] = sw[j]; nexp++; end
    for (int k = 0; k < exp_nsent; k++) begin
      b = mem[(rd_p + k) % 64];
      for (int j = 7; j >= 0; j--) begin expb[nexp] = b[j]; nexp++; end
    end
  endtask

  task automatic start_pkt(input int pre, input int len, input logic [15:0] sw,
                           input int per, input bit ticks);
    build_exp(pre, len, sw);
    @(negedge clk);
    pre_len = 4'(pre); pkt_len = 8'(len); sync_word = sw;
    ncap = 0; tick_cnt = 1; tick_per = per; tick_on = ticks;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_pkt(input string tag);
    int guard, bad;
    guard = 0;
    while (busy && guard < 50000) begin @(negedge clk); guard++; end
    @(negedge clk); @(negedge clk);
    tick_on = 1'b0;
    chk({tag, " R1 bit count"}, ncap, nexp);
    bad = 0;
    for (int i = 0; i < nexp && i < ncap; i++) if (cap[i] != expb[i]) bad++;
    chk({tag, " R1 bit mismatches"}, bad, 0);
    chk({tag, " R4 sent_irq"}, int'(sent_irq), int'(!exp_unf));
    chk({tag, " R6 underflow"}, int'(underflow), int'(exp_unf));
    chk({tag, " R3 busy low"}, int'(busy), 0);
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk); irq_clr = m;
    @(negedge clk); irq_clr = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int left;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 busy", int'(busy), 0);
    chk("R8 tx_valid", int'(tx_valid), 0);
    chk("R8 fifo_rd", int'(fifo_rd), 0);
    chk("R8 flags", int'({sent_irq, underflow}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table: R1 R3 R6 R7 R9
    foreach (VECS[v]) begin
      wr_p = rd_p;
      push(int'(VECS[v].nq));
      start_pkt(int'(VECS[v].pre), int'(VECS[v].len), VECS[v].sync, int'(VECS[v].per), 1'b1);
      finish_pkt($sformatf("vec%0d", v));
      chk($sformatf("vec%0d R3 R9 bytes left", v), wr_p - rd_p, int'(VECS[v].nq) - exp_nsent);
      clr(2'b11);
    end

    // R3: nine bytes, length three, three commands
    wr_p = rd_p;
    push(9);
    for (int p = 0; p < 3; p++) begin
      start_pkt(1, 3, 16'h2DD4, 1, 1'b1);
      finish_pkt($sformatf("split%0d", p));
      repeat (20) @(negedge clk);
      chk($sformatf("split%0d R3 stays idle", p), int'(busy), 0);
      chk($sformatf("split%0d R3 bytes left", p), wr_p - rd_p, 6 - 3 * p);
      clr(2'b01);
      chk($sformatf("split%0d R4 cleared", p), int'(sent_irq), 0);
    end

    // R5: start and new configuration while busy have no effect
    wr_p = rd_p;
    push(4);
    start_pkt(1, 2, 16'hA5A5, 1, 1'b1);
    repeat (5) @(negedge clk);
    pkt_len = 8'd4; pre_len = 4'd3; sync_word = 16'h0F0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_pkt("latch");
    chk("R5 bytes left after ignored start", wr_p - rd_p, 2);
    clr(2'b11);

    // R2: no ticks, no bits
    wr_p = rd_p;
    push(1);
    start_pkt(0, 1, 16'h5A5A, 1, 1'b0);
    repeat (30) @(negedge clk);
    chk("R2 no bits without tick", ncap, 0);
    chk("R2 holds busy without tick", int'(busy), 1);
    tick_on = 1'b1;
    finish_pkt("pause");

    // R4 / R6 clear selectivity
    clr(2'b10);
    chk("R4 sent kept on other clear", int'(sent_irq), 1);
    clr(2'b01);
    chk("R4 sent cleared", int'(sent_irq), 0);
    wr_p = rd_p;
    start_pkt(0, 2, 16'h0001, 1, 1'b1);
    finish_pkt("dry");
    clr(2'b01);
    chk("R6 underflow kept on other clear", int'(underflow), 1);
    clr(2'b10);
    chk("R6 underflow cleared", int'(underflow), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule